// File: doc/BRIEF.md
# Greedy Sparse Decomposition Engine

This block breaks a stored block of signal samples into a short ordered list of dictionary waveforms, called atoms. It runs the greedy matching pursuit loop entirely in logic. While the engine is idle, a host writes the sample buffer and a small dictionary of equal-length atoms into two local memories. The host then pulses `start`. On each iteration the engine does four things:

1. It slides every atom across the whole buffer, one sample at a time, and forms a weight at each offset.
2. It keeps the single best (atom, offset, weight) triple.
3. It subtracts the scaled winning atom from the buffer in place.
4. It appends the triple to a small event table.

The loop ends when either the event table is full or the energy of what remains is small enough. `done` rises only after the final residual write has landed. The host then reads the event table and the residual, which now sits in the same memory that held the input.

Samples and atoms are signed Q1.15. Each offset uses one multiply-accumulate per tap, so one iteration costs about `ATOMS × (SAMPLES − ATOM_LEN + 1) × ATOM_LEN` cycles. The stopping test compares summed squared samples against `rms_thr² × SAMPLES`, so no square root is needed.

Top module: `mp_engine`

## Requirements
- R1: After reset, `busy`=0, `done`=0 and `evt_count`=0.
- R2: The cycle after `start` is sampled while idle, `busy` is 1. `busy` stays 1 until `done` goes to 1, at which point `busy` is 0. `busy` and `done` are never both 1. `done` stays 1 until the next accepted `start`.
- R3: A `start` pulse while `busy`=1 has no effect: `busy` stays 1, and the run's events and residual match an undisturbed run.
- R4: The weight of atom a at offset k (k = 0 … SAMPLES−ATOM_LEN) is the sum over taps j of `sig[k+j]·atom[a][j]`, arithmetically shifted right by 15 and saturated to [−32768, 32767]. Each iteration picks the largest signed weight over all atoms and offsets.
- R5: On equal weights, the lower atom number wins; for the same atom, the lower offset wins.
- R6: For j = 0 … ATOM_LEN−1, `sig[idx+j]` becomes `sat16(sig[idx+j] − ((w·atom[a][j]) >>> 15))`, where w, a and idx are the winning weight, atom and offset.
- R7: Event entry n (read address n) holds the atom number, weight and offset chosen in iteration n. `evt_count` equals the number of entries written. The table output is registered, with one cycle of latency.
- R8: The run stops before a new iteration once MAX_ITER entries exist.
- R9: Before every iteration, including the first, the run stops if `Σ sig[i]²` ≤ `rms_thr²·SAMPLES`. With equality it stops, and zero entries may result.
- R10: While idle, `sig_rd_data` returns the word at `sig_rd_addr` one cycle after the address is presented. This is how the residual is read after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_wr_en | input | 1 | Host sample write strobe (used only while idle) |
| sig_wr_addr | input | $clog2(SAMPLES) | Host sample write address |
| sig_wr_data | input | DW | Host sample write data, signed Q1.15 |
| sig_rd_addr | input | $clog2(SAMPLES) | Host sample/residual read address |
| sig_rd_data | output | DW | Registered sample/residual read data |
| atom_wr_en | input | 1 | Host atom write strobe (used only while idle) |
| atom_wr_addr | input | $clog2(ATOMS·ATOM_LEN) | Atom word address = atom·ATOM_LEN + tap |
| atom_wr_data | input | DW | Atom tap value, signed Q1.15 |
| rms_thr | input | DW | Unsigned residual amplitude threshold, sampled at start |
| start | input | 1 | Launch pulse |
| busy | output | 1 | High from accepted start until done |
| done | output | 1 | High once the run is complete, until next start |
| evt_rd_addr | input | $clog2(MAX_ITER) | Event table read index |
| evt_atom | output | $clog2(ATOMS) | Registered atom number of the entry |
| evt_weight | output | DW | Registered signed weight of the entry |
| evt_index | output | $clog2(SAMPLES) | Registered offset of the entry |
| evt_count | output | $clog2(MAX_ITER+1) | Number of entries written in the last run |

## Verification
A random buffer and dictionary exercise the full sixteen-iteration loop, with a stray `start` injected mid-run. This separates correct argmax, subtraction and ordering from an engine that restarts or drops iterations. A buffer holding the same pattern at two offsets, with two identical atoms, tells the tie rule apart from a last-wins or index-first search. A buffer filled with one constant value, paired with a threshold exactly at and one step below its energy, separates ≤ from <. A full-scale constant buffer and atom force weight saturation and a near-cancelling subtraction.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_EN, ST_EN_DRAIN, ST_DECIDE, ST_CORR,
    ST_CORR_DRAIN, ST_SUB, ST_SUB_DRAIN, ST_LOG
  } mp_state_e;

  typedef enum logic [1:0] {PM_EN, PM_CORR, PM_SUB} pipe_mode_e;
endpackage

// File: rtl/mp_sdp_ram.sv
module mp_sdp_ram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mp_window_mac.sv
module mp_window_mac #(
  parameter int DW    = 16,
  parameter int ACC_W = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic                 in_first,
  input  logic                 in_last,
  input  logic signed [DW-1:0] in_a,
  input  logic signed [DW-1:0] in_b,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_weight
);
  localparam int SH = DW - 1;

  logic signed [2*DW-1:0]  prod;
  logic signed [ACC_W-1:0] acc, sum, shifted;
  logic signed [DW-1:0]    wsat;

  always_comb begin
    prod    = in_a * in_b;
    sum     = (in_first ? '0 : acc) + ACC_W'(prod);
    shifted = sum >>> SH;
    if (&shifted[ACC_W-1:DW-1] || ~|shifted[ACC_W-1:DW-1])
      wsat = shifted[DW-1:0];
    else
      wsat = shifted[ACC_W-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      out_vld    <= 1'b0;
      out_weight <= '0;
    end else begin
      out_vld <= in_vld && in_last;
      if (in_vld) acc <= sum;
      if (in_vld && in_last) out_weight <= wsat;
    end
  end
endmodule

// File: rtl/mp_argmax.sv
module mp_argmax #(
  parameter int DW  = 16,
  parameter int ATW = 3,
  parameter int SAW = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 cand_vld,
  input  logic signed [DW-1:0] cand_w,
  input  logic [ATW-1:0]       cand_atom,
  input  logic [SAW-1:0]       cand_idx,
  output logic signed [DW-1:0] best_w,
  output logic [ATW-1:0]       best_atom,
  output logic [SAW-1:0]       best_idx,
  output logic                 best_have
);
  // strict greater-than keeps the earlier candidate on ties (R5)
  logic take;
  assign take = cand_vld && (!best_have || cand_w > best_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      best_w    <= '0;
      best_atom <= '0;
      best_idx  <= '0;
      best_have <= 1'b0;
    end else if (clear) begin
      best_have <= 1'b0;
    end else if (take) begin
      best_w    <= cand_w;
      best_atom <= cand_atom;
      best_idx  <= cand_idx;
      best_have <= 1'b1;
    end
  end

  // R4: within one search the kept weight never drops
  p_best_monotone_r4: assert property (@(posedge clk) disable iff (rst)
    (best_have && $past(best_have) && !$past(clear)) |-> (best_w >= $past(best_w)));
endmodule

// File: rtl/mp_engine.sv
module mp_engine import mp_pkg::*; #(
  parameter int SAMPLES  = 512,
  parameter int ATOM_LEN = 32,
  parameter int ATOMS    = 8,
  parameter int MAX_ITER = 16,
  parameter int DW       = 16,
  parameter int ACC_W    = 40,
  localparam int SAW = $clog2(SAMPLES),
  localparam int AAW = $clog2(ATOMS * ATOM_LEN),
  localparam int ATW = $clog2(ATOMS),
  localparam int EVW = $clog2(MAX_ITER),
  localparam int CW  = $clog2(MAX_ITER + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sig_wr_en,
  input  logic [SAW-1:0] sig_wr_addr,
  input  logic [DW-1:0]  sig_wr_data,
  input  logic [SAW-1:0] sig_rd_addr,
  output logic [DW-1:0]  sig_rd_data,
  input  logic           atom_wr_en,
  input  logic [AAW-1:0] atom_wr_addr,
  input  logic [DW-1:0]  atom_wr_data,
  input  logic [DW-1:0]  rms_thr,
  input  logic           start,
  output logic           busy,
  output logic           done,
  input  logic [EVW-1:0] evt_rd_addr,
  output logic [ATW-1:0] evt_atom,
  output logic [DW-1:0]  evt_weight,
  output logic [SAW-1:0] evt_index,
  output logic [CW-1:0]  evt_count
);
  localparam int TW       = $clog2(ATOM_LEN);
  localparam int ENW      = 2 * DW + SAW + 1;
  localparam int RW       = 2 * DW + 1;
  localparam int LAST_OFF = SAMPLES - ATOM_LEN;

  mp_state_e  st;
  pipe_mode_e p_mode;
  logic [ATW-1:0] c_atom, p_atom, q_atom;
  logic [SAW-1:0] c_off, p_off, q_off, p_waddr;
  logic [TW-1:0]  c_tap;
  logic           d_cnt;
  logic [CW-1:0]  iter;
  logic [ENW-1:0] energy, thr_lim;
  logic           p_vld, p_first, p_last;

  logic           iss_vld, iss_first, iss_last;
  logic [SAW-1:0] eng_sig_ra, sig_ra, sig_wa;
  logic [AAW-1:0] eng_atom_ra;
  logic           eng_we, sig_we;
  logic [DW-1:0]  sig_wd, sig_rd, atom_rd, res_new;
  logic signed [DW-1:0]   sig_rd_s, atom_rd_s;
  logic signed [2*DW-1:0] sq, sprod, sshift;
  logic signed [RW-1:0]   diff;

  logic                 mac_vld;
  logic signed [DW-1:0] mac_w, best_w;
  logic [ATW-1:0]       best_atom;
  logic [SAW-1:0]       best_idx;
  logic                 best_have;

  assign sig_rd_s  = $signed(sig_rd);
  assign atom_rd_s = $signed(atom_rd);

  // ---------------- read issue ----------------
  always_comb begin
    iss_vld     = 1'b0;
    iss_first   = 1'b0;
    iss_last    = 1'b0;
    eng_sig_ra  = '0;
    eng_atom_ra = '0;
    case (st)
      ST_EN: begin
        iss_vld    = 1'b1;
        eng_sig_ra = c_off;
        iss_last   = (c_off == SAW'(SAMPLES - 1));
      end
      ST_CORR: begin
        iss_vld     = 1'b1;
        eng_sig_ra  = c_off + SAW'(c_tap);
        eng_atom_ra = AAW'(AAW'(c_atom) * AAW'(ATOM_LEN)) + AAW'(c_tap);
        iss_first   = (c_tap == '0);
        iss_last    = (c_tap == TW'(ATOM_LEN - 1));
      end
      ST_SUB: begin
        iss_vld     = 1'b1;
        eng_sig_ra  = best_idx + SAW'(c_tap);
        eng_atom_ra = AAW'(AAW'(best_atom) * AAW'(ATOM_LEN)) + AAW'(c_tap);
        iss_last    = (c_tap == TW'(ATOM_LEN - 1));
      end
      default: ;
    endcase
  end

  // ---------------- residual update and energy term ----------------
  always_comb begin
    sq     = sig_rd_s * sig_rd_s;
    sprod  = best_w * atom_rd_s;
    sshift = sprod >>> (DW - 1);
    diff   = RW'(sig_rd_s) - RW'(sshift);
    if (&diff[RW-1:DW-1] || ~|diff[RW-1:DW-1])
      res_new = diff[DW-1:0];
    else
      res_new = diff[RW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
  end

  assign eng_we = p_vld && (p_mode == PM_SUB);
  assign sig_ra = busy ? eng_sig_ra : sig_rd_addr;
  assign sig_we = busy ? eng_we     : sig_wr_en;
  assign sig_wa = busy ? p_waddr    : sig_wr_addr;
  assign sig_wd = busy ? res_new    : sig_wr_data;
  assign sig_rd_data = sig_rd;
  assign evt_count   = iter;

  mp_sdp_ram #(.WIDTH(DW), .DEPTH(SAMPLES)) u_sig (
    .clk(clk), .we(sig_we), .waddr(sig_wa), .wdata(sig_wd),
    .raddr(sig_ra), .rdata(sig_rd));

  mp_sdp_ram #(.WIDTH(DW), .DEPTH(ATOMS * ATOM_LEN)) u_atom (
    .clk(clk), .we(atom_wr_en && !busy), .waddr(atom_wr_addr), .wdata(atom_wr_data),
    .raddr(busy ? eng_atom_ra : atom_wr_addr), .rdata(atom_rd));

  mp_window_mac #(.DW(DW), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst),
    .in_vld(p_vld && (p_mode == PM_CORR)), .in_first(p_first), .in_last(p_last),
    .in_a(sig_rd_s), .in_b(atom_rd_s),
    .out_vld(mac_vld), .out_weight(mac_w));

  mp_argmax #(.DW(DW), .ATW(ATW), .SAW(SAW)) u_arg (
    .clk(clk), .rst(rst), .clear(st == ST_DECIDE),
    .cand_vld(mac_vld), .cand_w(mac_w), .cand_atom(q_atom), .cand_idx(q_off),
    .best_w(best_w), .best_atom(best_atom), .best_idx(best_idx), .best_have(best_have));

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      c_atom  <= '0;
      c_off   <= '0;
      c_tap   <= '0;
      d_cnt   <= 1'b0;
      iter    <= '0;
      energy  <= '0;
      thr_lim <= '0;
      p_vld   <= 1'b0;
      p_first <= 1'b0;
      p_last  <= 1'b0;
      p_mode  <= PM_EN;
      p_atom  <= '0;
      p_off   <= '0;
      p_waddr <= '0;
      q_atom  <= '0;
      q_off   <= '0;
    end else begin
      p_vld   <= iss_vld;
      p_first <= iss_first;
      p_last  <= iss_last;
      p_mode  <= (st == ST_CORR) ? PM_CORR : (st == ST_SUB) ? PM_SUB : PM_EN;
      p_atom  <= c_atom;
      p_off   <= c_off;
      p_waddr <= eng_sig_ra;
      if (p_vld && p_mode == PM_CORR && p_last) begin
        q_atom <= p_atom;
        q_off  <= p_off;
      end
      if (p_vld && p_mode == PM_EN) energy <= energy + ENW'($unsigned(sq));

      case (st)
        ST_IDLE: if (start) begin
          busy    <= 1'b1;
          done    <= 1'b0;
          iter    <= '0;
          energy  <= '0;
          c_off   <= '0;
          thr_lim <= ENW'(rms_thr) * ENW'(rms_thr) * ENW'(SAMPLES);
          st      <= ST_EN;
        end
        ST_EN: if (c_off == SAW'(SAMPLES - 1)) st <= ST_EN_DRAIN;
               else c_off <= c_off + 1'b1;
        ST_EN_DRAIN: st <= ST_DECIDE;
        ST_DECIDE: begin
          if (iter == CW'(MAX_ITER) || energy <= thr_lim) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            c_atom <= '0;
            c_off  <= '0;
            c_tap  <= '0;
            st     <= ST_CORR;
          end
        end
        ST_CORR: begin
          if (c_tap == TW'(ATOM_LEN - 1)) begin
            c_tap <= '0;
            if (c_off == SAW'(LAST_OFF)) begin
              c_off <= '0;
              if (c_atom == ATW'(ATOMS - 1)) begin
                d_cnt <= 1'b0;
                st    <= ST_CORR_DRAIN;
              end else c_atom <= c_atom + 1'b1;
            end else c_off <= c_off + 1'b1;
          end else c_tap <= c_tap + 1'b1;
        end
        ST_CORR_DRAIN: if (d_cnt) st <= ST_SUB;
                       else d_cnt <= 1'b1;
        ST_SUB: if (c_tap == TW'(ATOM_LEN - 1)) st <= ST_SUB_DRAIN;
                else c_tap <= c_tap + 1'b1;
        ST_SUB_DRAIN: st <= ST_LOG;
        ST_LOG: begin
          iter   <= iter + 1'b1;
          energy <= '0;
          c_off  <= '0;
          c_tap  <= '0;
          st     <= ST_EN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------- event table ----------------
  logic [ATW-1:0] ev_atom [MAX_ITER];
  logic [DW-1:0]  ev_w    [MAX_ITER];
  logic [SAW-1:0] ev_idx  [MAX_ITER];

  always_ff @(posedge clk) begin
    if (st == ST_LOG) begin
      ev_atom[iter[EVW-1:0]] <= best_atom;
      ev_w[iter[EVW-1:0]]    <= best_w;
      ev_idx[iter[EVW-1:0]]  <= best_idx;
    end
    evt_atom   <= ev_atom[evt_rd_addr];
    evt_weight <= ev_w[evt_rd_addr];
    evt_index  <= ev_idx[evt_rd_addr];
  end

  // ---------------- assertions ----------------
  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (rst) !(busy && done));
  p_done_hold_r2: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> done);
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && start && st != ST_DECIDE) |=> busy);
  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst) evt_count <= CW'(MAX_ITER));
  p_sub_window_r6: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> (SAW'(p_waddr - best_idx) < SAW'(ATOM_LEN)));
  p_log_has_best_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOG) |-> best_have);
endmodule

// File: tb/tb_mp_engine.sv
module tb_mp_engine;
  localparam int NS = 48, AL = 8, NA = 4, MI = 16;
  localparam int SAW = $clog2(NS), AAW = $clog2(NA * AL), ATW = $clog2(NA);
  localparam int EVW = $clog2(MI), CW = $clog2(MI + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic sig_wr_en = 0, atom_wr_en = 0, start = 0;
  logic [SAW-1:0] sig_wr_addr = '0, sig_rd_addr = '0;
  logic [AAW-1:0] atom_wr_addr = '0;
  logic [15:0] sig_wr_data = '0, atom_wr_data = '0, rms_thr = '0;
  logic [EVW-1:0] evt_rd_addr = '0;
  logic [15:0] sig_rd_data, evt_weight;
  logic busy, done;
  logic [ATW-1:0] evt_atom;
  logic [SAW-1:0] evt_index;
  logic [CW-1:0] evt_count;

  always #5 clk = ~clk;

  mp_engine #(.SAMPLES(NS), .ATOM_LEN(AL), .ATOMS(NA), .MAX_ITER(MI)) dut (
    .clk(clk), .rst(rst),
    .sig_wr_en(sig_wr_en), .sig_wr_addr(sig_wr_addr), .sig_wr_data(sig_wr_data),
    .sig_rd_addr(sig_rd_addr), .sig_rd_data(sig_rd_data),
    .atom_wr_en(atom_wr_en), .atom_wr_addr(atom_wr_addr), .atom_wr_data(atom_wr_data),
    .rms_thr(rms_thr), .start(start), .busy(busy), .done(done),
    .evt_rd_addr(evt_rd_addr), .evt_atom(evt_atom), .evt_weight(evt_weight),
    .evt_index(evt_index), .evt_count(evt_count));

  int total = 0, fails = 0;
  longint m_sig [NS];
  longint m_atom [NA*AL];
  longint m_ea [MI], m_ew [MI], m_ei [MI];
  int m_cnt;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat16(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic model_run(input longint thr);
    longint en, acc, w, bw, ba, bi;
    bit have;
    m_cnt = 0;
    forever begin
      en = 0;
      for (int i = 0; i < NS; i++) en += m_sig[i] * m_sig[i];
      if (m_cnt == MI || en <= thr * thr * NS) break;
      have = 0; bw = 0; ba = 0; bi = 0;
      for (int a = 0; a < NA; a++)
        for (int k = 0; k <= NS - AL; k++) begin
          acc = 0;
          for (int j = 0; j < AL; j++) acc += m_sig[k+j] * m_atom[a*AL+j];
          w = sat16(acc >>> 15);
          if (!have || w > bw) begin have = 1; bw = w; ba = a; bi = k; end
        end
      for (int j = 0; j < AL; j++)
        m_sig[bi+j] = sat16(m_sig[bi+j] - ((bw * m_atom[ba*AL+j]) >>> 15));
      m_ea[m_cnt] = ba; m_ew[m_cnt] = bw; m_ei[m_cnt] = bi;
      m_cnt++;
    end
  endtask

  task automatic host_load();
    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      sig_wr_en = 1; sig_wr_addr = SAW'(i); sig_wr_data = 16'(m_sig[i]);
    end
    @(negedge clk) sig_wr_en = 0;
    for (int i = 0; i < NA*AL; i++) begin
      @(negedge clk);
      atom_wr_en = 1; atom_wr_addr = AAW'(i); atom_wr_data = 16'(m_atom[i]);
    end
    @(negedge clk) atom_wr_en = 0;
  endtask

  task automatic run_engine(input int thr, input bit poke);
    int cyc = 0;
    @(negedge clk);
    rms_thr = 16'(thr); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R2", "busy after start", longint'(busy), 1);
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
      chk(busy === 1'b1, "R3", "busy after start while busy", longint'(busy), 1);
    end
    while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
    chk(done === 1'b1 && busy === 1'b0, "R2", "done high with busy low",
        longint'({done, busy}), 2);
  endtask

  task automatic compare_all(input string tag);
    int bad = 0;
    longint first_act = 0, first_exp = 0;
    chk(int'(evt_count) == m_cnt, "R7", {tag, " event count"}, longint'(evt_count), m_cnt);
    for (int k = 0; k < m_cnt && k < MI; k++) begin
      evt_rd_addr = EVW'(k);
      @(negedge clk);
      chk(longint'(evt_atom) == m_ea[k], "R4", {tag, " event atom"}, longint'(evt_atom), m_ea[k]);
      chk(longint'($signed(evt_weight)) == m_ew[k], "R4", {tag, " event weight"},
          longint'($signed(evt_weight)), m_ew[k]);
      chk(longint'(evt_index) == m_ei[k], "R7", {tag, " event index"}, longint'(evt_index), m_ei[k]);
    end
    for (int i = 0; i < NS; i++) begin
      sig_rd_addr = SAW'(i);
      @(negedge clk);
      if (longint'($signed(sig_rd_data)) != m_sig[i]) begin
        if (bad == 0) begin first_act = longint'($signed(sig_rd_data)); first_exp = m_sig[i]; end
        bad++;
      end
    end
    // R6 / R10: residual read back through the host port
    chk(bad == 0, "R6", {tag, " residual word"}, first_act, first_exp);
  endtask

  function automatic longint rnd(input int span);
    return longint'(int'($urandom_range(2*span)) - span);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy === 0 && done === 0 && evt_count == 0, "R1", "reset state",
        longint'({busy, done, evt_count}), 0);

    // random run with stray start (R3, R8)
    for (int i = 0; i < NS; i++) m_sig[i] = rnd(8000);
    for (int i = 0; i < NA*AL; i++) m_atom[i] = rnd(16000);
    host_load();
    sig_rd_addr = SAW'(5);
    @(negedge clk);
    chk(longint'($signed(sig_rd_data)) == m_sig[5], "R10", "host read latency",
        longint'($signed(sig_rd_data)), m_sig[5]);
    model_run(0);
    run_engine(0, 1);
    chk(evt_count == CW'(MI), "R8", "iteration limit", longint'(evt_count), MI);
    compare_all("random");
    @(negedge clk);
    chk(done === 1'b1, "R2", "done held while idle", longint'(done), 1);

    // energy boundary (R9)
    for (int i = 0; i < NS; i++) m_sig[i] = 100;
    for (int i = 0; i < NA*AL; i++) m_atom[i] = rnd(12000);
    host_load();
    model_run(100);
    run_engine(100, 0);
    chk(evt_count == 0, "R9", "stop at equal energy", longint'(evt_count), 0);
    compare_all("thr_eq");
    model_run(99);
    run_engine(99, 0);
    chk(evt_count != 0, "R9", "run below threshold", longint'(evt_count), m_cnt);
    compare_all("thr_below");

    // ties (R5)
    for (int i = 0; i < NS; i++) m_sig[i] = 0;
    for (int j = 0; j < AL; j++) begin
      longint pv;
      case (j)
        0: pv = 3000;  1: pv = -5000; 2: pv = 4000;  3: pv = 1000;
        4: pv = -2000; 5: pv = 5000;  6: pv = -4000; default: pv = 2500;
      endcase
      m_sig[3+j] = pv; m_sig[20+j] = pv;
      m_atom[j] = pv; m_atom[AL+j] = pv;
    end
    for (int i = 2*AL; i < NA*AL; i++) m_atom[i] = rnd(1000);
    host_load();
    model_run(0);
    run_engine(0, 0);
    evt_rd_addr = '0;
    @(negedge clk);
    chk(evt_atom == 0, "R5", "tie keeps lower atom", longint'(evt_atom), 0);
    chk(evt_index == 3, "R5", "tie keeps lower offset", longint'(evt_index), 3);
    compare_all("tie");

    // saturation (R4, R6)
    for (int i = 0; i < NS; i++) m_sig[i] = 30000;
    for (int i = 0; i < AL; i++) m_atom[i] = 30000;
    for (int i = AL; i < NA*AL; i++) m_atom[i] = rnd(8000);
    host_load();
    model_run(0);
    run_engine(0, 0);
    evt_rd_addr = '0;
    @(negedge clk);
    chk($signed(evt_weight) == 32767, "R4", "weight saturates",
        longint'($signed(evt_weight)), 32767);
    compare_all("sat");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule